// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital sequencer behind a single-wire LIN physical layer. It decides whether the bus driver may pull the line low, what the host sees on its receive pin, whether the external voltage regulator is switched on, and whether the strong slave termination or only the weak pullup is connected to the bus. Analog work such as thresholds, slope shaping and current limiting happens elsewhere. The block sees the bus only as a digitized level from a comparator, and it drives only enable and level signals.

There are four modes: unpowered, sleep, standby and normal. A supply drop forces unpowered from any mode. When the supply returns, the host enable picks normal or sleep. In sleep, two filtered wake sources are watched. One is a remote wake: after the bus has been seen recessive, it must stay dominant for a whole filter window and then be released. The other is a local wake: the active-low wake input must stay low for its own filter window. Either wake moves the block to standby. In standby the receive pin is pulled low, which tells the host that a wake request is pending. Raising the enable from sleep or standby enters normal mode. In normal mode the driven level follows the transmit input and the receive pin follows the bus. There is no limit on how long the transmit input may stay low. An overtemperature flag silences the driver without changing the mode.

The bus level and the local wake input each pass through a two-flop synchronizer before they are used. The two filter windows are parameters counted in clock cycles. A window of 25 to 150 µs, nominally 50 µs, is the intended setting.

Top module: `lin_mode_ctrl`

## Requirements
- R1: During reset, and from the first clock edge at which supply_ok_i is sampled low in any mode, the block is unpowered. In that state drv_en_o=0, drv_lvl_o=1 (recessive), rxd_o=1 (released), inh_o=0 and strong_term_o=0 (weak pullup).
- R2: In the unpowered state, if supply_ok_i is sampled high, the next mode is normal when en_i=1 and sleep when en_i=0.
- R3: If en_i is sampled low while the supply is good, the block enters sleep from normal. Sleep outputs are drv_en_o=0, drv_lvl_o=1, rxd_o=1, inh_o=0 and strong_term_o=0.
- R4: Remote wake moves the block from sleep to standby. It occurs only after bus_lvl_i (1 = recessive, 0 = dominant) has been seen recessive in sleep, then dominant for BUS_WAKE_CYC consecutive synchronized samples, then recessive again. A bus that is already dominant when sleep starts does not count until it has first been seen recessive.
- R5: A dominant pulse shorter than BUS_WAKE_CYC synchronized samples is ignored, and the block stays in sleep.
- R6: Local wake moves sleep to standby once wake_n_i (active low) has been low for LOCAL_WAKE_CYC consecutive synchronized samples. Shorter low pulses are ignored.
- R7: Standby outputs are drv_en_o=0, drv_lvl_o=1, rxd_o=0, inh_o=1 and strong_term_o=1.
- R8: If en_i is sampled high while the supply is good, the next mode is normal, whether the block is in sleep, standby or unpowered.
- R9: In normal mode, inh_o=1, strong_term_o=1 and drv_lvl_o equals txd_i (0 = dominant). rxd_o equals bus_lvl_i delayed by the two synchronizer stages. A transmit input held low for any length of time keeps the bus dominant.
- R10: While overtemp_i=1, drv_en_o=0 and drv_lvl_o=1 in the same cycle, with no clock edge needed. The mode is unchanged, so the driver comes back as soon as the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Host enable: 1 requests normal mode, 0 requests sleep |
| wake_n_i | input | 1 | Local wake input, active low, asynchronous |
| supply_ok_i | input | 1 | 1 when the supply is above the undervoltage threshold |
| overtemp_i | input | 1 | 1 while an overtemperature fault is present |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| bus_lvl_i | input | 1 | Digitized bus level, 1 = recessive, asynchronous |
| drv_en_o | output | 1 | Bus driver enable |
| drv_lvl_o | output | 1 | Level the driver imposes, 0 = dominant |
| rxd_o | output | 1 | Receive output to the host, 1 = released |
| inh_o | output | 1 | Regulator inhibit switch on |
| strong_term_o | output | 1 | 1 = strong termination, 0 = weak pullup |

## Verification
The overtemperature gate and the mode change caused by the enable can happen in the same cycle. The bench raises en_i from standby and asserts overtemp_i at the same falling edge. It then expects the normal-mode signature (rxd_o following the bus, inh_o on) with the driver still off. When the fault is released, it expects the driver to come back with no further enable edge, which shows that the fault did not disturb the mode register. A second coincidence is a supply drop while the block sits in standby with the wake input still low; it must fall to unpowered and, once the supply returns, come back in sleep.

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int BUS_WAKE_CYC   = 100,
  parameter int LOCAL_WAKE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic wake_n_i,
  input  logic supply_ok_i,
  input  logic overtemp_i,
  input  logic txd_i,
  input  logic bus_lvl_i,
  output logic drv_en_o,
  output logic drv_lvl_o,
  output logic rxd_o,
  output logic inh_o,
  output logic strong_term_o
);

  localparam int BW = $clog2(BUS_WAKE_CYC + 1);
  localparam int LW = $clog2(LOCAL_WAKE_CYC + 1);
  localparam logic [BW-1:0] BUS_TOP = BW'(BUS_WAKE_CYC);
  localparam logic [LW-1:0] LOC_TOP = LW'(LOCAL_WAKE_CYC);

  typedef enum logic [1:0] {ST_UNPOW, ST_SLEEP, ST_STBY, ST_NORM} mode_t;
  mode_t state, state_nx;

  logic [1:0] bus_sync, wk_sync;
  logic       bus_s, wk_s;
  logic [BW-1:0] bus_cnt;
  logic [LW-1:0] loc_cnt;
  logic       rec_seen, armed;
  logic       in_sleep, remote_wake, local_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_sync <= 2'b11;
      wk_sync  <= 2'b11;
    end else begin
      bus_sync <= {bus_sync[0], bus_lvl_i};
      wk_sync  <= {wk_sync[0], wake_n_i};
    end
  end

  assign bus_s    = bus_sync[1];
  assign wk_s     = wk_sync[1];
  assign in_sleep = (state == ST_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_cnt  <= '0;
      rec_seen <= 1'b0;
      armed    <= 1'b0;
    end else if (!in_sleep) begin
      bus_cnt  <= '0;
      rec_seen <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (bus_s) rec_seen <= 1'b1;
      if (bus_s || !rec_seen) bus_cnt <= '0;
      else if (bus_cnt != BUS_TOP) bus_cnt <= bus_cnt + 1'b1;
      if (bus_cnt == BUS_TOP) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loc_cnt <= '0;
    else if (!in_sleep || wk_s) loc_cnt <= '0;
    else if (loc_cnt != LOC_TOP) loc_cnt <= loc_cnt + 1'b1;
  end

  assign remote_wake = armed && bus_s;
  assign local_wake  = (loc_cnt == LOC_TOP);

  always_comb begin
    state_nx = state;
    if (!supply_ok_i)      state_nx = ST_UNPOW;
    else if (en_i)         state_nx = ST_NORM;
    else if (state == ST_NORM || state == ST_UNPOW) state_nx = ST_SLEEP;
    else if (in_sleep && (remote_wake || local_wake)) state_nx = ST_STBY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_UNPOW;
    else        state <= state_nx;
  end

  assign drv_en_o      = (state == ST_NORM) && !overtemp_i;
  assign drv_lvl_o     = drv_en_o ? txd_i : 1'b1;
  assign rxd_o         = (state == ST_NORM) ? bus_s : (state != ST_STBY);
  assign inh_o         = (state == ST_STBY) || (state == ST_NORM);
  assign strong_term_o = inh_o;

  // R1
  unpow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (!inh_o && !drv_en_o && rxd_o && !strong_term_o));

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok_i && !en_i) |=> (!drv_en_o && drv_lvl_o));

  // R7
  standby_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STBY && $past(state) != ST_STBY) |-> $past(state) == ST_SLEEP);

  // R8
  en_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok_i && en_i) |=> (inh_o && (rxd_o == bus_s)));

  // R10
  ot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overtemp_i && state == ST_NORM && supply_ok_i && en_i) |=> state == ST_NORM);

  // R4
  rwake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && state_nx == ST_STBY && !local_wake) |-> (armed && bus_s));

endmodule

// File: tb/test_lin_mode_ctrl.sv
module test_lin_mode_ctrl;
  localparam int NW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, wake_n_i = 1'b1, supply_ok_i = 1'b0, overtemp_i = 1'b0;
  logic txd_i = 1'b1, bus_lvl_i = 1'b1;
  logic drv_en_o, drv_lvl_o, rxd_o, inh_o, strong_term_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  lin_mode_ctrl #(.BUS_WAKE_CYC(NW), .LOCAL_WAKE_CYC(NW)) i_lin_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .wake_n_i(wake_n_i),
    .supply_ok_i(supply_ok_i), .overtemp_i(overtemp_i), .txd_i(txd_i),
    .bus_lvl_i(bus_lvl_i), .drv_en_o(drv_en_o), .drv_lvl_o(drv_lvl_o),
    .rxd_o(rxd_o), .inh_o(inh_o), .strong_term_o(strong_term_o));

  // fields: req[22:19] en wk sup ot txd bus [18:13] wait[12:5] exp drv lvl rxd inh term [4:0]
  localparam logic [22:0] VEC [0:24] = '{
    {4'd1,  6'b010011, 8'd3,  5'b01100},  // R1 unpowered
    {4'd2,  6'b011011, 8'd4,  5'b01100},  // R2 supply back, en low -> sleep
    {4'd8,  6'b111000, 8'd4,  5'b10011},  // R8 sleep -> normal
    {4'd9,  6'b111011, 8'd4,  5'b11111},  // R9 recessive
    {4'd10, 6'b111100, 8'd4,  5'b01011},  // R10 fault
    {4'd10, 6'b111000, 8'd4,  5'b10011},  // R10 fault cleared
    {4'd3,  6'b011011, 8'd4,  5'b01100},  // R3 en low -> sleep
    {4'd5,  6'b011010, 8'd3,  5'b01100},  // R5 short dominant
    {4'd5,  6'b011011, 8'd4,  5'b01100},  // R5 still sleep
    {4'd4,  6'b011010, 8'd20, 5'b01100},  // R4 held dominant, not released
    {4'd4,  6'b011011, 8'd4,  5'b01011},  // R4 released -> standby
    {4'd8,  6'b111011, 8'd2,  5'b11111},  // R8 standby -> normal
    {4'd3,  6'b011011, 8'd2,  5'b01100},  // R3 sleep
    {4'd6,  6'b001011, 8'd4,  5'b01100},  // R6 short local pulse
    {4'd6,  6'b011011, 8'd4,  5'b01100},  // R6 still sleep
    {4'd6,  6'b001011, 8'd20, 5'b01011},  // R6 local wake -> standby
    {4'd1,  6'b010011, 8'd2,  5'b01100},  // R1 drop from standby
    {4'd2,  6'b111011, 8'd2,  5'b11111},  // R2 unpowered -> normal
    {4'd9,  6'b111010, 8'd4,  5'b11011},  // R9 bus dominant seen on rxd
    {4'd4,  6'b011010, 8'd20, 5'b01100},  // R4 stuck dominant at sleep entry
    {4'd4,  6'b011011, 8'd4,  5'b01100},  // R4 no wake without prior recessive
    {4'd7,  6'b001011, 8'd20, 5'b01011},  // R7 standby outputs
    {4'd1,  6'b000011, 8'd2,  5'b01100},  // R1 drop while wake held low
    {4'd2,  6'b011011, 8'd2,  5'b01100},  // R2 back to sleep
    {4'd3,  6'b011011, 8'd2,  5'b01100}   // R3 sleep stays
  };

  task automatic check(input int req, input logic [4:0] exp);
    logic [4:0] act;
    act = {drv_en_o, drv_lvl_o, rxd_o, inh_o, strong_term_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: outputs drv/lvl/rxd/inh/term actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] ins);
    {en_i, wake_n_i, supply_ok_i, overtemp_i, txd_i, bus_lvl_i} = ins;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 5'b01100);  // R1 reset state
    rst_n = 1'b1;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      apply(VEC[k][18:13]);
      repeat (int'(VEC[k][12:5])) @(negedge clk);
      check(int'(VEC[k][22:19]), VEC[k][4:0]);
    end

    // R9 long dominant transmit, no timeout
    @(negedge clk); apply(6'b111000);
    repeat (1000) @(negedge clk);
    check(9, 5'b10011);

    // R10 immediate gating without a clock edge
    #0.5 overtemp_i = 1'b1;
    #0.5 check(10, 5'b01011);
    @(negedge clk); overtemp_i = 1'b0;
    #0.5 check(10, 5'b10011);

    // enable rise and fault in the same cycle from standby (R8, R10)
    @(negedge clk); apply(6'b011011);
    repeat (3) @(negedge clk);
    apply(6'b001011);
    repeat (20) @(negedge clk);
    check(7, 5'b01011);
    apply(6'b111111);
    @(negedge clk);
    check(8, 5'b01111);
    overtemp_i = 1'b0;
    #0.5 check(10, 5'b11111);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule